// File: doc/BRIEF.md
# JTAG Indirect Register Access Target

This block is the test-port side of a chip's register access path. An IEEE 1149.1 TAP controller with a 4-bit instruction register decides which data register sits between `tdi_i` and `tdo_o`. Four data registers give indirect access to a small internal register file: an access-address register, an access-opcode register, a combined status-and-data register and a mode register. Every other instruction code selects a one-bit bypass register.

Software reaches an internal register in two phases. It loads the target address, loads write data into the data field if the access is a write, and then shifts an opcode into the access-opcode register. The opcode starts the access. For the slow registers (the five configuration words) the access stays pending until the TAP has spent `LAT` clock cycles in Run-Test-Idle. Software polls status-and-data until it reads COMPLETED or ERROR. Four fast registers finish in the same cycle the opcode is loaded and leave the status at IDLE. These are the port/statistics control register, the system-reset register, the error counters and the free-buffer counters.

All data registers shift least significant bit first.

Top module: `jit_target`

## Requirements
- R1: The TAP follows the 1149.1 state graph on rising `tck_i` edges. Five consecutive cycles with `tms_i` high reach Test-Logic-Reset from any state.
- R2: Deassertion of `rst_ni` and every cycle in Test-Logic-Reset set the instruction register to the bypass code 4'hF. The bypass register is one bit wide and captures 0. Every code other than 5, 6, 7 and 8 selects bypass.
- R3: Capture-IR loads 4'b0001, so the first bit shifted out of any IR scan is 1 and the next three are 0.
- R4: Code 5 selects the 12-bit access-address register and code 6 the 2-bit access-opcode register. Code 7 selects the 34-bit status-and-data register, with the status in bits [1:0] and the data in bits [33:2]. Code 8 selects the 4-bit mode register. Capture returns the held value of the selected register.
- R5: Loading opcode 0 (write) or 1 (read) at a configuration address (0x1E0 to 0x1E4) sets the status to BUSY (2'b01).
- R6: A pending access completes on its `LAT`-th clock edge spent in Run-Test-Idle, and edges in other states do not count. On completion the status becomes COMPLETED (2'b10). A read places the register value in the data field, and a write stores the data field that was present at launch.
- R7: Accesses to the fast registers take effect on the cycle of the opcode update and set the status to IDLE (2'b00); a fast read loads the data field at once. The fast registers are 0x200 (18 bits), 0x341 (8 bits), 0x300 (16 bits) and 0x310 (16 bits).
- R8: An unknown address or an opcode of 2 or 3 sets the status to ERROR (2'b11) at once and leaves the register file unchanged.
- R9: A write keeps only the low bits that fit the register's width, and reads return 0 above that width.
- R10: While the status is BUSY, a new opcode and any update of the status-and-data register are ignored.
- R11: The mode register holds the last value shifted into it and returns it on capture.
- R12: `rst_ni` low clears the register file, the address, the data field, the mode and the status (IDLE).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset of TAP and register state |
| tms_i | input | 1 | Test mode select, sampled on rising `tck_i` |
| tdi_i | input | 1 | Serial data in, shifted LSB first |
| tdo_o | output | 1 | Serial data out, valid in Shift-IR and Shift-DR, 0 elsewhere |

## Verification
The bench builds the block with `LAT` = 8. That is long enough that a full address, data and opcode reload fits inside one pending access, so R10 is reached, and short enough that the bench can land a poll exactly one Run-Test-Idle edge before completion and one edge after it. All nine internal registers are swept with two data patterns, and the expected read values come from each register's width. All sixteen instruction codes are walked to separate the bypass path from the four selected registers.

// File: rtl/jit_pkg.sv
`timescale 1ns/1ps
package jit_pkg;
  localparam int IR_W   = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ST_W   = 2;
  localparam int OP_W   = 2;
  localparam int MODE_W = 4;
  localparam int SD_W   = DATA_W + ST_W;
  localparam int NREG   = 9;
  localparam int LEN_W  = $clog2(SD_W + 1);

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_e;

  localparam logic [ST_W-1:0] ST_IDLE = 2'b00;
  localparam logic [ST_W-1:0] ST_BUSY = 2'b01;
  localparam logic [ST_W-1:0] ST_DONE = 2'b10;
  localparam logic [ST_W-1:0] ST_ERR  = 2'b11;

  localparam logic [IR_W-1:0] IR_ADDR = 4'd5;
  localparam logic [IR_W-1:0] IR_OPC  = 4'd6;
  localparam logic [IR_W-1:0] IR_SD   = 4'd7;
  localparam logic [IR_W-1:0] IR_MODE = 4'd8;
  localparam logic [IR_W-1:0] IR_BYP  = '1;
  localparam logic [IR_W-1:0] IR_CAP  = 4'b0001;

  localparam logic [OP_W-1:0] OP_WR = 2'd0;
  localparam logic [OP_W-1:0] OP_RD = 2'd1;

  localparam logic [ADDR_W-1:0] A_PORTCTL = 12'h200;
  localparam logic [ADDR_W-1:0] A_SYSRST  = 12'h341;
  localparam logic [ADDR_W-1:0] A_ERRCNT  = 12'h300;
  localparam logic [ADDR_W-1:0] A_BUFFREE = 12'h310;
  localparam logic [ADDR_W-1:0] A_CFG0    = 12'h1E0;
  localparam int NCFG = 5;

  typedef struct packed {
    logic       hit;
    logic       fast;
    logic [3:0] idx;
    logic [5:0] width;
  } rdec_t;

  function automatic rdec_t reg_decode(input logic [ADDR_W-1:0] a);
    rdec_t d;
    d = '0;
    case (a)
      A_PORTCTL: d = '{1'b1, 1'b1, 4'd0, 6'd18};
      A_SYSRST:  d = '{1'b1, 1'b1, 4'd1, 6'd8};
      A_ERRCNT:  d = '{1'b1, 1'b1, 4'd2, 6'd16};
      A_BUFFREE: d = '{1'b1, 1'b1, 4'd3, 6'd16};
      default:
        if (a >= A_CFG0 && a < A_CFG0 + ADDR_W'(NCFG))
          d = '{1'b1, 1'b0, 4'(a - A_CFG0) + 4'd4, 6'd32};
    endcase
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic [5:0] w);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(w));
    return m;
  endfunction
endpackage

// File: rtl/jit_tap_fsm.sv
`timescale 1ns/1ps
module jit_tap_fsm
  import jit_pkg::*;
(
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  output tap_e state_o
);
  tap_e st_q, st_d;

  always_comb begin
    case (st_q)
      TLR:     st_d = tms_i ? TLR    : RTI;
      RTI:     st_d = tms_i ? SEL_DR : RTI;
      SEL_DR:  st_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR:  st_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:   st_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR:  st_d = tms_i ? UPD_DR : PA_DR;
      PA_DR:   st_d = tms_i ? EX2_DR : PA_DR;
      EX2_DR:  st_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR:  st_d = tms_i ? SEL_DR : RTI;
      SEL_IR:  st_d = tms_i ? TLR    : CAP_IR;
      CAP_IR:  st_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:   st_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR:  st_d = tms_i ? UPD_IR : PA_IR;
      PA_IR:   st_d = tms_i ? EX2_IR : PA_IR;
      EX2_IR:  st_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR:  st_d = tms_i ? SEL_DR : RTI;
      default: st_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) st_q <= TLR;
    else         st_q <= st_d;

  assign state_o = st_q;
endmodule

// File: rtl/jit_regfile.sv
`timescale 1ns/1ps
module jit_regfile
  import jit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              fast_o,
  output logic [DATA_W-1:0] rdata_o
);
  rdec_t dec;
  logic [DATA_W-1:0] mem_q [NREG];

  assign dec     = reg_decode(addr_i);
  assign hit_o   = dec.hit;
  assign fast_o  = dec.fast;
  assign rdata_o = dec.hit ? mem_q[dec.idx] : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i && dec.hit) begin
      mem_q[dec.idx] <= wdata_i & width_mask(dec.width);
    end
endmodule

// File: rtl/jit_op_engine.sv
`timescale 1ns/1ps
module jit_op_engine
  import jit_pkg::*;
#(
  parameter int LAT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              in_rti_i,
  input  logic              sd_load_i,
  input  logic [DATA_W-1:0] sd_wdata_i,
  output logic [ST_W-1:0]   status_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic              rf_hit_i,
  input  logic              rf_fast_i,
  input  logic [DATA_W-1:0] rf_rdata_i
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [ST_W-1:0]   st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_rd_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q, data_q;
  logic busy, accept, op_ok, finish;

  assign busy   = (st_q == ST_BUSY);
  assign accept = launch_i && !busy;
  assign op_ok  = (op_i == OP_WR) || (op_i == OP_RD);
  assign finish = busy && in_rti_i && (cnt_q == '0);

  assign rf_addr_o  = busy ? pend_addr_q : addr_i;
  assign rf_wdata_o = busy ? pend_data_q : data_q;
  assign rf_we_o    = (accept && op_ok && rf_hit_i && rf_fast_i && op_i == OP_WR)
                   || (finish && !pend_rd_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      pend_rd_q   <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      data_q      <= '0;
    end else if (accept) begin
      if (!op_ok || !rf_hit_i) begin
        st_q <= ST_ERR;
      end else if (rf_fast_i) begin
        st_q <= ST_IDLE;
        if (op_i == OP_RD) data_q <= rf_rdata_i;
      end else begin
        st_q        <= ST_BUSY;
        cnt_q       <= CNT_W'(LAT - 1);
        pend_rd_q   <= (op_i == OP_RD);
        pend_addr_q <= addr_i;
        pend_data_q <= data_q;
      end
    end else if (finish) begin
      st_q <= ST_DONE;
      if (pend_rd_q) data_q <= rf_rdata_i;
    end else if (busy && in_rti_i) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (sd_load_i && !busy) begin
      data_q <= sd_wdata_i;
    end

  assign status_o = st_q;
  assign data_o   = data_q;
endmodule

// File: rtl/jit_target.sv
`timescale 1ns/1ps
module jit_target
  import jit_pkg::*;
#(
  parameter int LAT = 16
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o
);
  tap_e              tap_state;
  logic [IR_W-1:0]   ir_sr, ir_q;
  logic [SD_W-1:0]   dr_sr, dr_cap, dr_shift;
  logic [LEN_W-1:0]  dr_len;
  logic [ADDR_W-1:0] addr_q, rf_addr;
  logic [MODE_W-1:0] mode_q;
  logic [ST_W-1:0]   status;
  logic [DATA_W-1:0] data, rf_wdata, rf_rdata;
  logic rf_we, rf_hit, rf_fast, launch, sd_load;

  jit_tap_fsm u_tap (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(tap_state)
  );

  always_comb begin
    case (ir_q)
      IR_ADDR: begin dr_len = LEN_W'(ADDR_W); dr_cap = SD_W'(addr_q); end
      IR_OPC:  begin dr_len = LEN_W'(OP_W);   dr_cap = '0; end
      IR_SD:   begin dr_len = LEN_W'(SD_W);   dr_cap = {data, status}; end
      IR_MODE: begin dr_len = LEN_W'(MODE_W); dr_cap = SD_W'(mode_q); end
      default: begin dr_len = LEN_W'(1);      dr_cap = '0; end
    endcase
  end

  // serial input enters at the top of the selected register's length
  always_comb begin
    dr_shift = dr_sr >> 1;
    for (int i = 0; i < SD_W; i++)
      if (i == int'(dr_len) - 1) dr_shift[i] = tdi_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      ir_sr  <= '0;
      ir_q   <= IR_BYP;
      dr_sr  <= '0;
      addr_q <= '0;
      mode_q <= '0;
    end else begin
      case (tap_state)
        TLR:    ir_q  <= IR_BYP;
        CAP_IR: ir_sr <= IR_CAP;
        SH_IR:  ir_sr <= {tdi_i, ir_sr[IR_W-1:1]};
        UPD_IR: ir_q  <= ir_sr;
        CAP_DR: dr_sr <= dr_cap;
        SH_DR:  dr_sr <= dr_shift;
        UPD_DR: begin
          if (ir_q == IR_ADDR)      addr_q <= dr_sr[ADDR_W-1:0];
          else if (ir_q == IR_MODE) mode_q <= dr_sr[MODE_W-1:0];
        end
        default: ;
      endcase
    end

  assign launch  = (tap_state == UPD_DR) && (ir_q == IR_OPC);
  assign sd_load = (tap_state == UPD_DR) && (ir_q == IR_SD);

  jit_op_engine #(.LAT(LAT)) u_eng (
    .clk_i     (tck_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .op_i      (dr_sr[OP_W-1:0]),
    .addr_i    (addr_q),
    .in_rti_i  (tap_state == RTI),
    .sd_load_i (sd_load),
    .sd_wdata_i(dr_sr[SD_W-1:ST_W]),
    .status_o  (status),
    .data_o    (data),
    .rf_addr_o (rf_addr),
    .rf_we_o   (rf_we),
    .rf_wdata_o(rf_wdata),
    .rf_hit_i  (rf_hit),
    .rf_fast_i (rf_fast),
    .rf_rdata_i(rf_rdata)
  );

  jit_regfile u_rf (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .addr_i (rf_addr),
    .we_i   (rf_we),
    .wdata_i(rf_wdata),
    .hit_o  (rf_hit),
    .fast_o (rf_fast),
    .rdata_o(rf_rdata)
  );

  always_comb begin
    case (tap_state)
      SH_IR:   tdo_o = ir_sr[0];
      SH_DR:   tdo_o = dr_sr[0];
      default: tdo_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/jit_target_chk.sv
`timescale 1ns/1ps
module jit_target_chk
  import jit_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input tap_e            state_i,
  input logic [IR_W-1:0] ir_i,
  input logic [ST_W-1:0] status_i,
  input logic            launch_i,
  input logic [OP_W-1:0] op_i,
  input logic            hit_i,
  input logic            fast_i
);
  logic [2:0] ones_q;
  logic       accept, op_ok;

  assign accept = launch_i && (status_i != ST_BUSY);
  assign op_ok  = (op_i == OP_WR) || (op_i == OP_RD);

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)            ones_q <= '0;
    else if (!tms_i)        ones_q <= '0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;

  a_r1_five_ones_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == 3'd5) |-> (state_i == TLR));

  a_r2_reset_state_bypass: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TLR) |=> (ir_i == IR_BYP));

  a_r5_slow_goes_busy: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (accept && op_ok && hit_i && !fast_i) |=> (status_i == ST_BUSY));

  a_r6_count_only_in_rti: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (status_i == ST_BUSY && state_i != RTI) |=> (status_i == ST_BUSY));

  a_r7_fast_idle: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (accept && op_ok && hit_i && fast_i) |=> (status_i == ST_IDLE));

  a_r8_bad_access_error: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (accept && (!op_ok || !hit_i)) |=> (status_i == ST_ERR));

  a_r10_busy_leaves_only_to_done: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (status_i == ST_BUSY) |=> (status_i == ST_BUSY || status_i == ST_DONE));
endmodule

bind jit_target jit_target_chk u_chk (
  .tck_i   (tck_i),
  .rst_ni  (rst_ni),
  .tms_i   (tms_i),
  .state_i (tap_state),
  .ir_i    (ir_q),
  .status_i(status),
  .launch_i(launch),
  .op_i    (dr_sr[1:0]),
  .hit_i   (rf_hit),
  .fast_i  (rf_fast)
);

// File: tb/jit_target_tb.sv
`timescale 1ns/1ps
module jit_target_tb_top;
  localparam int LAT = 8;

  logic tck = 1'b0, rst_ni = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo;
  int checks = 0, errors = 0;

  jit_target #(.LAT(LAT)) dut_i (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo)
  );

  always #2.5 tck = ~tck;

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic ms, input logic di, output logic dout);
    @(negedge tck);
    tms = ms; tdi = di;
    #1 dout = tdo;
  endtask

  task automatic idle(input int n);
    logic d;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, d);
  endtask

  task automatic scan_ir(input logic [3:0] code);
    logic d;
    logic [3:0] cap;
    tick(1, 0, d); tick(1, 0, d); tick(0, 0, d); tick(0, 0, d);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i], d);
      cap[i] = d;
    end
    tick(1, 0, d); tick(0, 0, d);
    check("R3 capture-ir", 40'(cap), 40'h1);
  endtask

  task automatic scan_dr(input int len, input logic [39:0] din, output logic [39:0] dout);
    logic d;
    dout = '0;
    tick(1, 0, d); tick(0, 0, d); tick(0, 0, d);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i], d);
      dout[i] = d;
    end
    tick(1, 0, d); tick(0, 0, d);
  endtask

  task automatic launch(input logic [11:0] a, input logic [1:0] op);
    logic [39:0] o;
    scan_ir(4'd5); scan_dr(12, 40'(a), o);
    scan_ir(4'd6); scan_dr(2, 40'(op), o);
  endtask

  task automatic load_data(input logic [31:0] v);
    logic [39:0] o;
    scan_ir(4'd7); scan_dr(34, {6'd0, v, 2'b00}, o);
  endtask

  task automatic poll(output logic [39:0] o);
    scan_ir(4'd7);
    for (int i = 0; i < 40; i++) begin
      scan_dr(34, 40'h0, o);
      if (o[1:0] != 2'b01) break;
    end
  endtask

  function automatic logic [11:0] reg_addr(input int k);
    case (k)
      0: return 12'h200; 1: return 12'h341; 2: return 12'h300; 3: return 12'h310;
      default: return 12'h1E0 + 12'(k - 4);
    endcase
  endfunction

  function automatic int reg_width(input int k);
    case (k)
      0: return 18; 1: return 8; 2: return 16; 3: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int w);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    return m[31:0];
  endfunction

  logic [39:0] o;
  logic d;
  logic [31:0] pats [2];

  initial begin : watchdog
    repeat (150000) @(posedge tck);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'h5A5A_C3C3;
    repeat (3) @(negedge tck);
    rst_ni = 1'b1;
    tick(0, 0, d);

    // R2: after reset the bypass bit sits in the path and captures 0
    scan_dr(8, 40'hB3, o);
    check("R2 bypass after reset", o & 40'hFF, 40'h66);

    // R12: reset state of address, status/data and mode
    scan_ir(4'd5); scan_dr(12, 40'h0, o); check("R12 addr reset", o, 40'h0);
    scan_ir(4'd7); scan_dr(34, 40'h0, o); check("R12 status/data reset", o, 40'h0);
    scan_ir(4'd8); scan_dr(4, 40'h0, o);  check("R12 mode reset", o, 40'h0);

    // R2: every unassigned code behaves as one-bit bypass
    for (int c = 0; c < 16; c++) begin
      if (c >= 5 && c <= 8) continue;
      scan_ir(4'(c));
      scan_dr(8, 40'hB3, o);
      check($sformatf("R2 code %0d bypass", c), o & 40'hFF, 40'h66);
    end

    // R11: mode holds written values
    scan_ir(4'd8); scan_dr(4, 40'hA, o); scan_dr(4, 40'h5, o);
    check("R11 mode A", o & 40'hF, 40'hA);
    scan_dr(4, 40'h0, o);
    check("R11 mode 5", o & 40'hF, 40'h5);

    // R4: address register holds and returns its 12 bits
    scan_ir(4'd5); scan_dr(12, 40'h3C5, o); scan_dr(12, 40'h0, o);
    check("R4 addr width/capture", o, 40'h3C5);

    // R12: register file clear after reset (slow read)
    launch(12'h1E0, 2'd1); poll(o);
    check("R12 regfile cleared", o, 40'h2);

    // R5 R6 R7 R9 sweep over every internal register and two patterns
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 9; k++) begin
        load_data(pats[p] ^ 32'(k));
        launch(reg_addr(k), 2'd0);
        if (k < 4) begin
          scan_ir(4'd7); scan_dr(34, 40'h0, o);
          check($sformatf("R7 fast write idle k=%0d", k), 40'(o[1:0]), 40'h0);
          launch(reg_addr(k), 2'd1);
          scan_ir(4'd7); scan_dr(34, 40'h0, o);
          check($sformatf("R7 R9 fast read k=%0d", k), o,
                {6'd0, (pats[p] ^ 32'(k)) & mask_of(reg_width(k)), 2'b00});
        end else begin
          idle(LAT - 3);
          scan_ir(4'd7); scan_dr(34, 40'h0, o);
          check($sformatf("R5 busy one edge early k=%0d", k), 40'(o[1:0]), 40'h1);
          scan_dr(34, 40'h0, o);
          check($sformatf("R6 done at LAT edge k=%0d", k), 40'(o[1:0]), 40'h2);
          launch(reg_addr(k), 2'd1); poll(o);
          check($sformatf("R6 R9 slow read k=%0d", k), o,
                {6'd0, (pats[p] ^ 32'(k)) & mask_of(reg_width(k)), 2'b10});
        end
      end
    end

    // R8: unknown addresses and bad opcodes
    begin
      logic [11:0] bad [5];
      bad[0] = 12'h1DF; bad[1] = 12'h1E5; bad[2] = 12'h201; bad[3] = 12'h000; bad[4] = 12'hFFF;
      for (int i = 0; i < 5; i++) begin
        launch(bad[i], 2'd1);
        scan_ir(4'd7); scan_dr(34, 40'h0, o);
        check($sformatf("R8 unknown addr %h", bad[i]), 40'(o[1:0]), 40'h3);
      end
      load_data(32'hDEAD_BEEF);
      launch(12'h1E3, 2'd2);
      scan_ir(4'd7); scan_dr(34, 40'h0, o);
      check("R8 opcode 2 error", 40'(o[1:0]), 40'h3);
      launch(12'h1E3, 2'd1); poll(o);
      check("R8 opcode 2 no write", o, {6'd0, pats[1] ^ 32'd7, 2'b10});
    end

    // R10: second launch and data load during BUSY are ignored
    load_data(32'h1111_2222);
    launch(12'h1E1, 2'd0);
    load_data(32'h9999_9999);
    launch(12'h1E2, 2'd0);
    poll(o);
    check("R10 first op completes", 40'(o[1:0]), 40'h2);
    launch(12'h1E1, 2'd1); poll(o);
    check("R10 first write landed", o, {6'd0, 32'h1111_2222, 2'b10});
    launch(12'h1E2, 2'd1); poll(o);
    check("R10 second write ignored", o, {6'd0, pats[1] ^ 32'd6, 2'b10});

    // R7: fast write after COMPLETED returns status to IDLE
    load_data(32'h0000_00AB);
    launch(12'h341, 2'd0);
    scan_ir(4'd7); scan_dr(34, 40'h0, o);
    check("R7 fast after done idle", 40'(o[1:0]), 40'h0);

    // R1: five TMS-high cycles from Shift-DR land in reset, IR back to bypass
    scan_ir(4'd8);
    tick(1, 0, d); tick(0, 0, d); tick(0, 0, d); tick(0, 1, d);
    for (int i = 0; i < 5; i++) tick(1, 0, d);
    tick(0, 0, d);
    scan_dr(8, 40'hB3, o);
    check("R1 five ones reach reset", o & 40'hFF, 40'h66);

    // R12: asynchronous reset clears the register file mid-run
    @(negedge tck); rst_ni = 1'b0;
    @(negedge tck); rst_ni = 1'b1;
    tick(0, 0, d);
    launch(12'h1E1, 2'd1); poll(o);
    check("R12 regfile cleared by rst", o, 40'h2);
    launch(12'h200, 2'd1);
    scan_ir(4'd7); scan_dr(34, 40'h0, o);
    check("R12 fast reg cleared", o, 40'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule